// File: doc/BRIEF.md
# Character Display Write Address Sequencer

This block owns the single address counter shared by three small memories of a character display controller: a display code store of three lines with ten 8-bit character codes each, a mark store of twenty 5-bit entries, and a glyph store of 32 glyphs by 8 rows of 5 pixel bits. It takes decoded commands from a host interface and turns them into memory writes. Each write goes out as one write-enable pulse with the target select, the address and the data, already trimmed to the width of the target memory.

The display code store and the mark store share one address space that has gaps in it. The lines sit at 00h-09h, 10h-19h and 20h-29h, and the marks at 40h-53h. The counter therefore steps within the region that is currently addressed and wraps at that region's edges. A clear command fills every display code location with the blank code, one location per cycle. While the fill runs, a busy flag is raised and all commands are dropped.

Top module: `dram_addr_ctr`

## Requirements
- R1: After reset, addr_cnt is 00h, inc_mode is 1, busy is 0, wr_en is 0 and the write target is the display store (wr_sel 0).
- R2: Command 5 (cmd_op=3'd5) loads cmd_arg[6:0] into the counter. A value in 00h-09h, 10h-19h or 20h-29h selects the display store (wr_sel 0). A value in 40h-53h selects the mark store (wr_sel 1). Any other value is ignored and leaves both the counter and the target unchanged.
- R3: Command 6 loads cmd_arg[7:0] into the counter and selects the glyph store (wr_sel 2).
- R4: Command 7 gives wr_en for exactly one cycle, starting one clock after it is accepted. That cycle carries wr_sel equal to the current target and wr_addr equal to the counter before the step. The counter then moves by +1 if inc_mode is 1, or by -1 if inc_mode is 0.
- R5: A write to the display store carries all 8 bits of cmd_arg. A write to the mark or glyph store carries only cmd_arg[4:0], with wr_data[7:5] forced to 0.
- R6: In the display store, stepping up from 09h, 19h or 29h goes to 00h, 10h or 20h respectively, and stepping down from a line start goes to the end of that same line.
- R7: In the mark store, stepping up from 53h gives 40h, and stepping down from 40h gives 53h.
- R8: In the glyph store, the counter wraps modulo 256 (FFh+1 gives 00h, 00h-1 gives FFh).
- R9: Command 3 sets inc_mode to cmd_arg[0].
- R10: Command 4 moves the counter by -1 when cmd_arg[0]=0 and by +1 when cmd_arg[0]=1. It follows the wrap rules of R6 to R8 and produces no write.
- R11: Command 2 sets the counter to 00h and the target to the display store. It produces no write and leaves inc_mode unchanged.
- R12: Command 1 raises busy one clock after it is accepted. It then issues 30 writes on consecutive cycles, each with wr_sel 0 and data 20h, to 00h-09h, 10h-19h and 20h-29h in that order. Busy falls with the last write. The counter holds its old value during the fill, and afterwards addr_cnt is 00h, inc_mode is 1 and the target is the display store.
- R13: While busy is 1, cmd_valid is ignored. No command changes the counter or the mode during the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Command code: 0 none, 1 clear, 2 home, 3 entry mode, 4 shift, 5 set display/mark address, 6 set glyph address, 7 write |
| cmd_arg | input | 8 | Command argument or write data |
| wr_en | output | 1 | Memory write enable, one cycle per write |
| wr_sel | output | 2 | Write target: 0 display, 1 mark, 2 glyph |
| wr_addr | output | 8 | Write address |
| wr_data | output | 8 | Write data, trimmed to the width of the target |
| addr_cnt | output | 8 | Current address counter |
| inc_mode | output | 1 | 1 = step up after a write, 0 = step down |
| busy | output | 1 | Clear fill in progress |

## Verification
The bench builds the block with its default geometry: three lines of ten codes on a stride of sixteen, twenty marks based at 40h, 256 glyph rows and 5-bit narrow data. With these values every wrap edge can be reached in a few commands: the 09h-to-00h and 10h-to-19h line wraps, the 53h/40h mark wrap and the FFh/00h glyph wrap. The full 30-location clear also stays short enough to check write by write, together with a command dropped in the middle of it.

// File: rtl/dac_pkg.sv
package dac_pkg;

  parameter int unsigned AW = 8;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_CLEAR  = 3'd1,
    OP_HOME   = 3'd2,
    OP_ENTRY  = 3'd3,
    OP_SHIFT  = 3'd4,
    OP_SET_DM = 3'd5,
    OP_SET_CG = 3'd6,
    OP_WRITE  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    TGT_DISP  = 2'd0,
    TGT_MARK  = 2'd1,
    TGT_GLYPH = 2'd2
  } tgt_e;

  // step inside one display line: lines start on multiples of stride
  function automatic logic [AW-1:0] disp_step(logic [AW-1:0] a, logic up,
                                              int unsigned len, int unsigned stride);
    int unsigned ai, base, off;
    ai   = int'(a);
    base = (ai / stride) * stride;
    off  = ai % stride;
    if (up) off = (off + 1 >= len) ? 0 : off + 1;
    else    off = (off == 0) ? len - 1 : off - 1;
    return AW'(base + off);
  endfunction

  function automatic logic [AW-1:0] ring_step(logic [AW-1:0] a, logic up,
                                              int unsigned base, int unsigned cnt);
    int unsigned ai, last;
    ai   = int'(a);
    last = base + cnt - 1;
    if (up) ai = (ai >= last) ? base : ai + 1;
    else    ai = (ai <= base) ? last : ai - 1;
    return AW'(ai);
  endfunction

  function automatic logic is_disp_addr(logic [AW-1:0] a, int unsigned len,
                                        int unsigned lines, int unsigned stride);
    return ((int'(a) / stride) < lines) && ((int'(a) % stride) < len);
  endfunction

  function automatic logic is_mark_addr(logic [AW-1:0] a, int unsigned base,
                                        int unsigned cnt);
    return (int'(a) >= base) && (int'(a) < base + cnt);
  endfunction

  function automatic logic [7:0] narrow(logic [7:0] d, int unsigned w);
    logic [7:0] m;
    m = 8'((1 << w) - 1);
    return d & m;
  endfunction

endpackage

// File: rtl/dac_step.sv
module dac_step
  import dac_pkg::*;
#(
  parameter int unsigned LINE_LEN    = 10,
  parameter int unsigned LINE_STRIDE = 16,
  parameter int unsigned MARK_BASE   = 'h40,
  parameter int unsigned MARK_CNT    = 20,
  parameter int unsigned GLYPH_LOCS  = 256
) (
  input  logic [AW-1:0] addr,
  input  tgt_e          tgt,
  input  logic          up,
  output logic [AW-1:0] nxt
);

  always_comb begin
    case (tgt)
      TGT_MARK:  nxt = ring_step(addr, up, MARK_BASE, MARK_CNT);
      TGT_GLYPH: nxt = ring_step(addr, up, 0, GLYPH_LOCS);
      default:   nxt = disp_step(addr, up, LINE_LEN, LINE_STRIDE);
    endcase
  end

endmodule

// File: rtl/dac_clear_seq.sv
module dac_clear_seq
  import dac_pkg::*;
#(
  parameter int unsigned LINE_LEN    = 10,
  parameter int unsigned LINES       = 3,
  parameter int unsigned LINE_STRIDE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          last,
  output logic [AW-1:0] fill_addr
);

  localparam int unsigned LW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int unsigned CW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;

  logic          busy_q;
  logic [LW-1:0] line_q;
  logic [CW-1:0] col_q;
  logic          col_end;

  assign col_end   = (col_q == CW'(LINE_LEN - 1));
  assign last      = busy_q && col_end && (line_q == LW'(LINES - 1));
  assign busy      = busy_q;
  assign fill_addr = AW'(int'(line_q) * LINE_STRIDE + int'(col_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      line_q <= '0;
      col_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        line_q <= '0;
        col_q  <= '0;
      end
    end else if (last) begin
      busy_q <= 1'b0;
    end else if (col_end) begin
      col_q  <= '0;
      line_q <= line_q + 1'b1;
    end else begin
      col_q  <= col_q + 1'b1;
    end
  end

endmodule

// File: rtl/dram_addr_ctr.sv
module dram_addr_ctr
  import dac_pkg::*;
#(
  parameter int unsigned LINE_LEN    = 10,
  parameter int unsigned LINES       = 3,
  parameter int unsigned LINE_STRIDE = 16,
  parameter int unsigned MARK_BASE   = 'h40,
  parameter int unsigned MARK_CNT    = 20,
  parameter int unsigned GLYPHS      = 32,
  parameter int unsigned GLYPH_ROWS  = 8,
  parameter int unsigned NARROW_W    = 5,
  parameter logic [7:0]  BLANK       = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_arg,
  output logic       wr_en,
  output logic [1:0] wr_sel,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [7:0] addr_cnt,
  output logic       inc_mode,
  output logic       busy
);

  localparam int unsigned GLYPH_LOCS = GLYPHS * GLYPH_ROWS;

  op_e           op;
  tgt_e          tgt_q, sel_q;
  logic [AW-1:0] cnt_q, step_nxt, fill_addr, dm_addr;
  logic          inc_q, step_up, fill_busy, fill_last;
  logic          cmd_take, clear_start, dm_is_disp, dm_is_mark, cg_ok;
  logic          wr_q;
  logic [AW-1:0] waddr_q;
  logic [7:0]    wdata_q;

  assign op          = op_e'(cmd_op);
  assign cmd_take    = cmd_valid && !fill_busy;
  assign clear_start = cmd_take && (op == OP_CLEAR);
  assign step_up     = (op == OP_SHIFT) ? cmd_arg[0] : inc_q;
  assign dm_addr     = {1'b0, cmd_arg[6:0]};
  assign dm_is_disp  = is_disp_addr(dm_addr, LINE_LEN, LINES, LINE_STRIDE);
  assign dm_is_mark  = is_mark_addr(dm_addr, MARK_BASE, MARK_CNT);
  assign cg_ok       = int'(cmd_arg) < GLYPH_LOCS;

  dac_step #(
    .LINE_LEN(LINE_LEN), .LINE_STRIDE(LINE_STRIDE),
    .MARK_BASE(MARK_BASE), .MARK_CNT(MARK_CNT), .GLYPH_LOCS(GLYPH_LOCS)
  ) u_step (
    .addr(cnt_q), .tgt(tgt_q), .up(step_up), .nxt(step_nxt)
  );

  dac_clear_seq #(
    .LINE_LEN(LINE_LEN), .LINES(LINES), .LINE_STRIDE(LINE_STRIDE)
  ) u_clear (
    .clk(clk), .rst_n(rst_n), .start(clear_start),
    .busy(fill_busy), .last(fill_last), .fill_addr(fill_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      inc_q   <= 1'b1;
      tgt_q   <= TGT_DISP;
      wr_q    <= 1'b0;
      sel_q   <= TGT_DISP;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      wr_q <= 1'b0;
      if (fill_busy) begin
        wr_q    <= 1'b1;
        sel_q   <= TGT_DISP;
        waddr_q <= fill_addr;
        wdata_q <= BLANK;
        if (fill_last) begin
          cnt_q <= '0;
          inc_q <= 1'b1;
          tgt_q <= TGT_DISP;
        end
      end else if (cmd_take) begin
        case (op)
          OP_HOME: begin
            cnt_q <= '0;
            tgt_q <= TGT_DISP;
          end
          OP_ENTRY: inc_q <= cmd_arg[0];
          OP_SHIFT: cnt_q <= step_nxt;
          OP_SET_DM: begin
            if (dm_is_disp) begin
              cnt_q <= dm_addr;
              tgt_q <= TGT_DISP;
            end else if (dm_is_mark) begin
              cnt_q <= dm_addr;
              tgt_q <= TGT_MARK;
            end
          end
          OP_SET_CG: begin
            if (cg_ok) begin
              cnt_q <= cmd_arg;
              tgt_q <= TGT_GLYPH;
            end
          end
          OP_WRITE: begin
            wr_q    <= 1'b1;
            sel_q   <= tgt_q;
            waddr_q <= cnt_q;
            wdata_q <= (tgt_q == TGT_DISP) ? cmd_arg : narrow(cmd_arg, NARROW_W);
            cnt_q   <= step_nxt;
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_en    = wr_q;
  assign wr_sel   = sel_q;
  assign wr_addr  = waddr_q;
  assign wr_data  = wdata_q;
  assign addr_cnt = cnt_q;
  assign inc_mode = inc_q;
  assign busy     = fill_busy;

endmodule

// File: rtl/dram_addr_ctr_chk.sv
module dram_addr_ctr_chk #(
  parameter int unsigned LINE_LEN    = 10,
  parameter int unsigned LINES       = 3,
  parameter int unsigned LINE_STRIDE = 16,
  parameter int unsigned MARK_BASE   = 'h40,
  parameter int unsigned MARK_CNT    = 20,
  parameter int unsigned NARROW_W    = 5,
  parameter logic [7:0]  BLANK       = 8'h20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] addr_cnt,
  input logic       inc_mode,
  input logic       busy,
  input logic       fill_last
);

  AST_DISP_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |->
      ((int'(wr_addr) / LINE_STRIDE) < LINES && (int'(wr_addr) % LINE_STRIDE) < LINE_LEN)); // R6

  AST_MARK_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1) |->
      (int'(wr_addr) >= MARK_BASE && int'(wr_addr) < MARK_BASE + MARK_CNT)); // R7

  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != 2'd0) |-> ((int'(wr_data) >> NARROW_W) == 0)); // R5

  AST_FILL_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |-> (wr_sel == 2'd0 && wr_data == BLANK)); // R12

  AST_CLEAR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (addr_cnt == 8'h00 && inc_mode && wr_en)); // R12

  AST_LAST_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last |=> !busy); // R12

  AST_FILL_FREEZES_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(addr_cnt) && $stable(inc_mode))); // R13

endmodule

bind dram_addr_ctr dram_addr_ctr_chk #(
  .LINE_LEN(LINE_LEN), .LINES(LINES), .LINE_STRIDE(LINE_STRIDE),
  .MARK_BASE(MARK_BASE), .MARK_CNT(MARK_CNT), .NARROW_W(NARROW_W), .BLANK(BLANK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
  .wr_data(wr_data), .addr_cnt(addr_cnt), .inc_mode(inc_mode), .busy(busy),
  .fill_last(fill_last)
);

// File: tb/test_dram_addr_ctr.sv
module test_dram_addr_ctr;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_arg = 8'd0;
  logic       wr_en, inc_mode, busy;
  logic [1:0] wr_sel;
  logic [7:0] wr_addr, wr_data, addr_cnt;

  int total = 0;
  int bad = 0;
  logic [17:0] exp_q[$];

  // bench-side model state
  int m_cnt = 0;
  int m_sel = 0;
  int m_inc = 1;

  always #2 clk = ~clk;

  dram_addr_ctr i_dram_addr_ctr (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .addr_cnt(addr_cnt), .inc_mode(inc_mode), .busy(busy)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // region-aware step, written independently of the design
  function automatic int b_step(int a, int sel, int up);
    int d = up ? 1 : -1;
    if (sel == 0) return (a & 8'hF0) + (((a & 15) + d + 10) % 10);
    if (sel == 1) return 8'h40 + ((a - 8'h40 + d + 20) % 20);
    return (a + d + 256) % 256;
  endfunction

  // monitor: every write must match the head of the expected queue
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_q.size() == 0) begin
        check("R4 unexpected write", {wr_sel, wr_addr, wr_data}, 0);
      end else begin
        logic [17:0] e;
        e = exp_q.pop_front();
        check("R4/R5/R12 write", {wr_sel, wr_addr, wr_data}, e);
      end
    end
  end

  task automatic do_cmd(int op, int arg);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 3'(op);
    cmd_arg   = 8'(arg);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wr(int d);
    int dd = (m_sel == 0) ? d : (d & 31);
    exp_q.push_back({2'(m_sel), 8'(m_cnt), 8'(dd)});
    do_cmd(7, d);
    m_cnt = b_step(m_cnt, m_sel, m_inc);
  endtask

  task automatic cnt_is(string req);
    check(req, addr_cnt, m_cnt);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int pre;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cnt", addr_cnt, 0);
    check("R1 inc", inc_mode, 1);
    check("R1 busy", busy, 0);
    check("R1 wr_en", wr_en, 0);
    wr(8'h41); cnt_is("R4 step up");                         // R1 target display
    do_cmd(5, 8'h09); m_cnt = 9; cnt_is("R2 load 09");
    wr(8'hC3); cnt_is("R6 wrap 09->00");
    do_cmd(3, 0); m_inc = 0;
    check("R9 dec mode", inc_mode, 0);
    do_cmd(5, 8'h10); m_cnt = 16;
    wr(8'h5A); cnt_is("R6 wrap 10->19");
    do_cmd(5, 8'h0A); cnt_is("R2 invalid ignored");
    do_cmd(5, 8'h2C); cnt_is("R2 invalid ignored 2C");
    wr(8'h11); cnt_is("R2 target kept display");
    do_cmd(5, 8'h40); m_cnt = 8'h40; m_sel = 1; cnt_is("R2 mark load");
    wr(8'hFF); cnt_is("R7 wrap 40->53");                      // R5 trimmed data
    wr(8'hE2); cnt_is("R7 step down");
    do_cmd(4, 1); m_cnt = b_step(m_cnt, 1, 1); cnt_is("R10 shift up");
    do_cmd(4, 1); m_cnt = b_step(m_cnt, 1, 1); cnt_is("R10 shift 53->40");
    check("R10 mark wrap value", addr_cnt, 8'h40);
    do_cmd(3, 1); m_inc = 1;
    check("R9 inc mode", inc_mode, 1);
    do_cmd(6, 8'hFF); m_cnt = 8'hFF; m_sel = 2; cnt_is("R3 glyph load");
    wr(8'hAB); cnt_is("R8 wrap FF->00");
    do_cmd(4, 0); m_cnt = b_step(m_cnt, 2, 0); cnt_is("R10 shift down");
    check("R8 wrap 00->FF", addr_cnt, 8'hFF);
    do_cmd(3, 0); m_inc = 0;
    do_cmd(2, 0); m_cnt = 0; m_sel = 0; cnt_is("R11 home");
    check("R11 mode kept", inc_mode, 0);
    wr(8'h33); cnt_is("R11 display target after home");
    do_cmd(5, 8'h25); m_cnt = 8'h25;
    pre = m_cnt;
    // R12 clear fill
    for (int l = 0; l < 3; l++)
      for (int c = 0; c < 10; c++)
        exp_q.push_back({2'd0, 8'(l * 16 + c), 8'h20});
    do_cmd(1, 0);
    check("R12 busy raised", busy, 1);
    n = 0;
    while (busy && n < 100) begin
      if (n == 2) begin
        cmd_valid = 1'b1; cmd_op = 3'd6; cmd_arg = 8'h55;
      end else if (n == 3) begin
        cmd_valid = 1'b1; cmd_op = 3'd3; cmd_arg = 8'h01;
      end else begin
        cmd_valid = 1'b0;
      end
      if (n == 6) begin
        check("R13 cnt frozen", addr_cnt, pre);
        check("R13 mode frozen", inc_mode, 0);
      end
      @(negedge clk);
      n++;
    end
    cmd_valid = 1'b0;
    check("R12 fill length", n, 30);
    m_cnt = 0; m_inc = 1; m_sel = 0;
    cnt_is("R12 cnt after clear");
    check("R12 inc after clear", inc_mode, 1);
    wr(8'h77); cnt_is("R12 display target after clear");
    repeat (3) @(negedge clk);
    check("R4 all writes seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule